// File: doc/BRIEF.md
# Incrementing Burst Bus Master with Idle-Beat Insertion

This block is the address-phase sequencer of a bus master on a single-master AHB-Lite style bus. A command port asks for one burst at a time. Each command carries a start address, a burst kind, a beat count and a flag that asks for an idle beat between data beats. The burst kind is either a fixed 4, 8 or 16 beat incrementing burst, or an incrementing burst of open length. The block then drives the transfer type, address, burst code, size and direction, and advances only when the slave signals ready.

With the idle-beat flag set, a BUSY cycle follows every data beat except the last. A BUSY cycle always lasts exactly one clock, whether or not the slave is stalling. This is the one point where the transfer type may change while the slave holds the bus in a wait state. A fixed burst always resumes with SEQ at the address the BUSY cycle showed. An open-length burst may be abandoned at that point: a waiting command starts a new burst with NONSEQ, or the stop input returns the bus to IDLE.

The command port is valid/ready. `cmd_ready` depends only on the block's own state and never on `cmd_valid`. A command is taken on any rising edge where both are high. The requester must hold the command fields stable while `cmd_valid` is high and `cmd_ready` is low. `cmd_ready` is high only while the bus is IDLE, or while an open-length burst sits in a BUSY cycle.

Top module: `ahb_burst_master`

## Requirements
- R1: After reset `htrans` is IDLE, `haddr` is 0, `hburst` is SINGLE, `hwrite` is 0, `cmd_ready` is 1 and `hsize` is 2 (word).
- R2: `cmd_ready` is 1 exactly when `htrans` is IDLE, or when `htrans` is BUSY and `hburst` is INCR. On the cycle after an accepted command, `htrans` is NONSEQ, `haddr` equals the command address and `hwrite` equals `cmd_write`. This holds even if `hready` was low.
- R3: `htrans` encodes IDLE=00, BUSY=01, NONSEQ=10 and SEQ=11. `cmd_kind` 1, 2 and 3 select fixed 4, 8 and 16 beat bursts, with `hburst` 011, 101 and 111. `cmd_kind` 0 selects an open-length burst of `cmd_beats` beats, with `hburst` 001. A `cmd_kind` 0 command with a count of 1 uses `hburst` 000, and a count of 0 is treated as 1.
- R4: A NONSEQ or SEQ beat is accepted on a rising edge with `hready` high. When that beat is not the last, `haddr` rises by 4 on that edge. `haddr` never changes on an edge with `hready` low, except when a new command is accepted.
- R5: While `htrans` is NONSEQ or SEQ and `hready` is low, `htrans`, `haddr`, `hburst` and `hwrite` all hold.
- R6: A burst carries exactly its beat count of NONSEQ/SEQ beats, and BUSY cycles do not count. After the last beat is accepted, `htrans` is IDLE and `haddr` keeps the last beat's address.
- R7: With `cmd_gap` set, every accepted beat except the last is followed by one BUSY cycle at the next beat's address. BUSY never lasts more than one cycle, and it is followed by SEQ at the same address, even when `hready` is low.
- R8: In a fixed burst, BUSY is always followed by SEQ. `stop_req` and a pending `cmd_valid` have no effect there.
- R9: In an open-length burst's BUSY cycle, a pending command is accepted and starts a new burst with NONSEQ. Otherwise `stop_req` high ends the burst with IDLE. Otherwise the burst continues with SEQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_addr | input | AW | Start address of the burst |
| cmd_kind | input | 2 | 0 open length, 1/2/3 fixed 4/8/16 beats |
| cmd_beats | input | BW | Beat count for open-length bursts |
| cmd_gap | input | 1 | Insert one BUSY cycle after each non-final beat |
| cmd_write | input | 1 | Direction of the burst |
| stop_req | input | 1 | End an open-length burst at its BUSY cycle |
| hready | input | 1 | Slave ready; low stretches the current transfer |
| htrans | output | 2 | Transfer type |
| haddr | output | AW | Transfer address |
| hburst | output | 3 | Burst code |
| hsize | output | 3 | Transfer size, fixed at word |
| hwrite | output | 1 | Transfer direction |

## Verification
Two functions can fall in the same cycle. One is the end of a BUSY cycle, which is a change of transfer type allowed during a wait. The other is the hand-over to a pending command or a stop request. Both are provoked by queueing the next command, and holding `stop_req`, while a gapped burst runs under a pseudo-random `hready`. As a result, BUSY cycles land on both stalled and ready edges, for both fixed and open-length bursts. A behavioural model in the bench predicts every output and `cmd_ready` on every clock, and each cycle is compared against it.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  localparam logic [2:0] HB_SINGLE = 3'b000;
  localparam logic [2:0] HB_INCR   = 3'b001;
  localparam logic [2:0] HB_INCR4  = 3'b011;
  localparam logic [2:0] HB_INCR8  = 3'b101;
  localparam logic [2:0] HB_INCR16 = 3'b111;
endpackage

// File: rtl/ahbm_burst_decode.sv
module ahbm_burst_decode #(
  parameter int BW = 5,
  parameter int CW = 5
) (
  input  logic [1:0]    kind,
  input  logic [BW-1:0] beats,
  output logic [2:0]    code,
  output logic [CW-1:0] total
);
  import ahbm_pkg::*;

  always_comb begin
    case (kind)
      2'd1: begin code = HB_INCR4;  total = CW'(4);  end
      2'd2: begin code = HB_INCR8;  total = CW'(8);  end
      2'd3: begin code = HB_INCR16; total = CW'(16); end
      default: begin
        total = (beats == '0) ? CW'(1) : CW'(beats);
        code  = (total == CW'(1)) ? HB_SINGLE : HB_INCR;
      end
    endcase
  end
endmodule

// File: rtl/ahbm_beat_counter.sv
module ahbm_beat_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left_q <= '0;
    else if (load) left_q <= load_val;
    else if (dec)  left_q <= left_q - CW'(1);
  end

  assign last = (left_q == CW'(1));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (left_q != '0));
endmodule

// File: rtl/ahbm_phase_ctrl.sv
module ahbm_phase_ctrl #(
  parameter int AW = 32,
  parameter int SIZE_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hready,
  input  logic          stop_req,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cmd_write,
  input  logic          cmd_gap,
  input  logic [2:0]    dec_code,
  input  logic          last,
  output logic          cmd_ready,
  output logic          load,
  output logic          dec,
  output logic [1:0]    htrans,
  output logic [AW-1:0] haddr,
  output logic [2:0]    hburst,
  output logic          hwrite
);
  import ahbm_pkg::*;

  localparam logic [AW-1:0] STEP = {{(AW-1){1'b0}}, 1'b1} << SIZE_LOG2;

  trans_e        tr_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    burst_q;
  logic          write_q;
  logic          gap_q;
  logic          acc;
  logic          beat_ok;

  always_comb begin
    cmd_ready = (tr_q == TR_IDLE) || (tr_q == TR_BUSY && burst_q == HB_INCR);
    acc       = cmd_valid && cmd_ready;
    beat_ok   = hready && (tr_q == TR_NSEQ || tr_q == TR_SEQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tr_q    <= TR_IDLE;
      addr_q  <= '0;
      burst_q <= HB_SINGLE;
      write_q <= 1'b0;
      gap_q   <= 1'b0;
    end else if (acc) begin
      tr_q    <= TR_NSEQ;
      addr_q  <= cmd_addr;
      burst_q <= dec_code;
      write_q <= cmd_write;
      gap_q   <= cmd_gap;
    end else if (tr_q == TR_BUSY) begin
      if (burst_q == HB_INCR && stop_req) tr_q <= TR_IDLE;
      else                                tr_q <= TR_SEQ;
    end else if (beat_ok) begin
      if (last) begin
        tr_q <= TR_IDLE;
      end else begin
        addr_q <= addr_q + STEP;
        tr_q   <= gap_q ? TR_BUSY : TR_SEQ;
      end
    end
  end

  assign load   = acc;
  assign dec    = beat_ok;
  assign htrans = tr_q;
  assign haddr  = addr_q;
  assign hburst = burst_q;
  assign hwrite = write_q;

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready && (tr_q == TR_NSEQ || tr_q == TR_SEQ))
      |=> ($stable(tr_q) && $stable(addr_q) && $stable(burst_q) && $stable(write_q)));
  // R8
  fixed_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_q == TR_BUSY && burst_q != HB_INCR) |=> (tr_q == TR_SEQ && $stable(addr_q)));
  // R7
  busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_q == TR_BUSY) |=> (tr_q != TR_BUSY));
  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (tr_q == TR_NSEQ && addr_q == $past(cmd_addr)));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !last) |=> (addr_q == $past(addr_q) + STEP));
endmodule

// File: rtl/ahb_burst_master.sv
module ahb_burst_master #(
  parameter int AW = 32,
  parameter int BW = 5,
  parameter int SIZE_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [1:0]    cmd_kind,
  input  logic [BW-1:0] cmd_beats,
  input  logic          cmd_gap,
  input  logic          cmd_write,
  input  logic          stop_req,
  input  logic          hready,
  output logic [1:0]    htrans,
  output logic [AW-1:0] haddr,
  output logic [2:0]    hburst,
  output logic [2:0]    hsize,
  output logic          hwrite
);
  localparam int CW = (BW > 5) ? BW : 5;

  logic [2:0]    dec_code;
  logic [CW-1:0] total;
  logic          load;
  logic          dec;
  logic          last;

  ahbm_burst_decode #(.BW(BW), .CW(CW)) u_decode (
    .kind  (cmd_kind),
    .beats (cmd_beats),
    .code  (dec_code),
    .total (total)
  );

  ahbm_beat_counter #(.CW(CW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (total),
    .dec      (dec),
    .last     (last)
  );

  ahbm_phase_ctrl #(.AW(AW), .SIZE_LOG2(SIZE_LOG2)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .hready    (hready),
    .stop_req  (stop_req),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_write (cmd_write),
    .cmd_gap   (cmd_gap),
    .dec_code  (dec_code),
    .last      (last),
    .cmd_ready (cmd_ready),
    .load      (load),
    .dec       (dec),
    .htrans    (htrans),
    .haddr     (haddr),
    .hburst    (hburst),
    .hwrite    (hwrite)
  );

  assign hsize = 3'(SIZE_LOG2);
endmodule

// File: tb/ahb_burst_master_bench.sv
module ahb_burst_master_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = 0;
  logic [1:0]  cmd_kind = 0;
  logic [4:0]  cmd_beats = 0;
  logic        cmd_gap = 0;
  logic        cmd_write = 0;
  logic        stop_req = 0;
  logic        hready = 1;
  logic [1:0]  htrans;
  logic [31:0] haddr;
  logic [2:0]  hburst;
  logic [2:0]  hsize;
  logic        hwrite;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit running = 0;
  bit rnd_ready = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int m_tr = 0, m_burst = 0, m_left = 0;
  logic [31:0] m_addr = 0;
  bit m_write = 0, m_gap = 0, m_acc = 0;

  always #10 clk = ~clk;

  ahb_burst_master u_ahb_burst_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_kind(cmd_kind), .cmd_beats(cmd_beats),
    .cmd_gap(cmd_gap), .cmd_write(cmd_write), .stop_req(stop_req),
    .hready(hready), .htrans(htrans), .haddr(haddr), .hburst(hburst),
    .hsize(hsize), .hwrite(hwrite)
  );

  function automatic bit model_ready();
    return (m_tr == 0) || (m_tr == 1 && m_burst == 1);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  // cycle model
  always @(posedge clk) begin
    if (rst_n) begin
      m_acc = cmd_valid && model_ready();
      if (m_acc) begin
        m_tr = 2; m_addr = cmd_addr; m_write = cmd_write; m_gap = cmd_gap;
        case (cmd_kind)
          2'd1: begin m_left = 4;  m_burst = 3; end
          2'd2: begin m_left = 8;  m_burst = 5; end
          2'd3: begin m_left = 16; m_burst = 7; end
          default: begin
            m_left = (cmd_beats == 0) ? 1 : int'(cmd_beats);
            m_burst = (m_left == 1) ? 0 : 1;
          end
        endcase
      end else if (m_tr == 1) begin
        m_tr = (m_burst == 1 && stop_req) ? 0 : 3;
      end else if (m_tr >= 2 && hready) begin
        m_left--;
        if (m_left == 0) m_tr = 0;
        else begin m_addr += 4; m_tr = m_gap ? 1 : 3; end
      end
    end
  end

  // per-cycle comparison and ready pattern
  always @(negedge clk) begin
    if (running) begin
      chk(htrans == 2'(m_tr), "htrans", htrans, m_tr);
      chk(haddr == m_addr, "haddr", haddr, m_addr);
      chk(hburst == 3'(m_burst), "hburst", hburst, m_burst);
      chk(hwrite == m_write, "hwrite", hwrite, m_write);
      chk(cmd_ready == model_ready(), "cmd_ready", cmd_ready, model_ready());
      chk(hsize == 3'd2, "hsize", hsize, 2);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    hready = rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // called right after a negedge; returns at the negedge after acceptance
  task automatic issue(input logic [31:0] a, input logic [1:0] k, input logic [4:0] n,
                       input bit g, input bit w);
    cmd_addr = a; cmd_kind = k; cmd_beats = n; cmd_gap = g; cmd_write = w;
    cmd_valid = 1;
    do @(negedge clk); while (!m_acc);
    #1;
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_tr != 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk(htrans == 2'b00, "reset htrans", htrans, 0);
    chk(haddr == 0, "reset haddr", haddr, 0);
    chk(hburst == 3'b000, "reset hburst", hburst, 0);
    chk(cmd_ready == 1, "reset cmd_ready", cmd_ready, 1);
    chk(hsize == 3'd2, "reset hsize", hsize, 2);
    rst_n = 1;
    running = 1;
    @(negedge clk);

    // R2/R3: fixed four-beat write, bus always ready
    cur_req = "R3";
    issue(32'h20, 2'd1, 5'd0, 0, 1);
    chk(htrans == 2'b10 && hburst == 3'b011, "R2 first beat NONSEQ/INCR4", {htrans, hburst}, 5'b10011);
    chk(haddr == 32'h20 && hwrite == 1, "R2 start address", haddr, 32'h20);
    wait_idle();
    cur_req = "R3";
    issue(32'h100, 2'd0, 5'd1, 0, 0);
    chk(hburst == 3'b000, "single-beat code", hburst, 0);
    wait_idle();
    issue(32'h140, 2'd0, 5'd0, 0, 0);
    chk(hburst == 3'b000, "zero count as one", hburst, 0);
    wait_idle();

    // R4/R5: stalls on an eight-beat burst
    cur_req = "R5";
    rnd_ready = 1;
    issue(32'h400, 2'd2, 5'd0, 0, 1);
    chk(hburst == 3'b101, "R4 INCR8 code", hburst, 5);
    wait_idle();

    // R6: open-length count
    cur_req = "R6";
    issue(32'h800, 2'd0, 5'd5, 0, 0);
    chk(hburst == 3'b001, "INCR code", hburst, 1);
    wait_idle();
    issue(32'h900, 2'd0, 5'd31, 0, 1);
    wait_idle();

    // R7: gaps in a sixteen-beat burst under stalls
    cur_req = "R7";
    issue(32'h1000, 2'd3, 5'd0, 1, 0);
    chk(hburst == 3'b111, "INCR16 code", hburst, 7);
    wait_idle();

    // R8: fixed burst ignores stop and a queued command at BUSY
    cur_req = "R8";
    stop_req = 1;
    issue(32'h2000, 2'd2, 5'd0, 1, 1);
    issue(32'h3000, 2'd1, 5'd0, 1, 0);
    stop_req = 0;
    wait_idle();

    // R9: abandon an open-length burst with a new command, then with stop
    cur_req = "R9";
    issue(32'h4000, 2'd0, 5'd12, 1, 0);
    issue(32'h5000, 2'd0, 5'd6, 1, 1);
    chk(htrans == 2'b10 && haddr == 32'h5000, "abandon to NONSEQ", haddr, 32'h5000);
    stop_req = 1;
    wait_idle();
    stop_req = 0;
    issue(32'h6000, 2'd0, 5'd9, 1, 0);
    wait_idle();
    rnd_ready = 0;
    issue(32'h7000, 2'd0, 5'd9, 1, 0);
    issue(32'h7800, 2'd1, 5'd0, 0, 1);
    wait_idle();

    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL %s watchdog act=running exp=done", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule